// File: doc/BRIEF.md
# Buddy-Aligned Cell Allocator

This block keeps an occupancy map of a fixed pool of memory cells and serves two commands: allocate and release. For an allocate, the requested cell count is rounded up to the next power of two. That rounded value picks a search level, and the block returns the lowest-addressed free block of that size that sits on a boundary of its own size. Only the cells actually asked for are then marked used. The rest of the aligned block stays free for later requests, so no internal fragmentation builds up. A release clears a cell range given as a start address and a count.

Commands enter on a valid/ready port, and results leave on a valid/ready port. One command is accepted per cycle, and its result is registered and appears on the cycle after acceptance. The block holds a single result slot. A command is accepted only when that slot is empty or is being drained in the same cycle. While the consumer holds the result back, the command port deasserts ready and the pending result stays frozen. Every command takes the same single cycle whatever the map holds, because the search and the marking are combinational trees over the whole map.

Top module: `buddy_alloc_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every cell is free, rsp_valid is 0 and cmd_ready is 1.
- R2: cmd_ready equals (not rsp_valid) or rsp_ready. A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1, and its result appears with rsp_valid = 1 right after that edge.
- R3: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_fail and rsp_addr hold their values.
- R4: An allocate searches at level L, the smallest L with 2^L at least the requested size. The returned address is a multiple of 2^L.
- R5: The returned address is the lowest-addressed aligned block of 2^L cells whose cells are all free.
- R6: A successful allocate marks exactly cells [addr, addr+size) as used and leaves every other cell unchanged.
- R7: When no aligned free block exists, an allocate returns rsp_fail = 1 and rsp_addr = 0, and the map is left unchanged.
- R8: An allocate with size 0, or with size greater than the pool (NCELLS), returns rsp_fail = 1 and rsp_addr = 0 and changes nothing.
- R9: A release clears cells [addr, addr+size), limited to the top of the pool, without checking for double release. Its result has rsp_fail = 0 and echoes the given address.
- R10: cmd_op = 0 selects allocate and cmd_op = 1 selects release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 1 | 0 = allocate, 1 = release |
| cmd_size | input | AW+1 | Cell count |
| cmd_addr | input | AW | Start cell for a release |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fail | output | 1 | Allocate could not be served |
| rsp_addr | output | AW | Allocated start cell, or echoed release address |

## Verification
The hardest case to reach is a request that fails even though enough free cells exist. The free cells are scattered so that no aligned block of the rounded size is fully clear. This comes from the gaps that exact-size marking leaves inside aligned blocks. The directed part builds such a map on purpose: it fills the pool, releases a single cell and then asks for two cells. The random part mixes many small odd sizes with releases taken from the live allocations, so partly used aligned blocks pile up. A bench model of the map predicts every address and failure.

// File: rtl/buddy_alloc_pkg.sv
package buddy_alloc_pkg;
  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } alloc_op_e;
endpackage

// File: rtl/buddy_roundup.sv
// Slice chain from the MSB: the first set bit seen with no feedback yet is
// the decision slice; ones below it push the result one bit higher.
module buddy_roundup #(
  parameter int SW = 9,
  parameter int LW = $clog2(SW + 1)
) (
  input  logic [SW-1:0] value,
  output logic [LW-1:0] level
);
  logic [SW:0] pow;

  always_comb begin
    logic fb;
    logic below;
    fb    = 1'b0;
    below = 1'b0;
    pow   = '0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (value[i] && !fb) begin
        below = |(value & ((SW'(1) << i) - SW'(1)));
        if (below) pow[i+1] = 1'b1;
        else       pow[i]   = 1'b1;
      end
      fb = fb | value[i];
    end
    level = '0;
    for (int i = 0; i <= SW; i++) begin
      if (pow[i]) level = LW'(i);
    end
  end

  always_comb begin
    AST_POW2_ONEHOT: assert ($onehot0(pow)) else $error("round-up not a power of two"); // R4
    AST_POW2_COVERS: assert ((value == '0) || ({1'b0, value} <= pow)) else $error("round-up below input"); // R4
  end
endmodule

// File: rtl/buddy_locator.sv
// Occupancy pyramid: each level ORs pairs of the level below; the chosen level
// is priority-scanned for its lowest clear entry.
module buddy_locator #(
  parameter int NCELLS = 256,
  parameter int AW     = $clog2(NCELLS),
  parameter int LW     = 4
) (
  input  logic [NCELLS-1:0] map,
  input  logic [LW-1:0]     level,
  output logic              found,
  output logic [AW-1:0]     addr
);
  logic [AW:0][NCELLS-1:0] occ;

  assign occ[0] = map;

  for (genvar l = 1; l <= AW; l++) begin : g_lvl
    for (genvar j = 0; j < NCELLS; j++) begin : g_node
      if (j < (NCELLS >> l)) begin : g_live
        assign occ[l][j] = occ[l-1][2*j] | occ[l-1][2*j+1];
      end else begin : g_pad
        assign occ[l][j] = 1'b1;
      end
    end
  end

  logic [NCELLS-1:0] sel;
  logic [AW-1:0]     idx;

  always_comb begin
    if (int'(level) <= AW) sel = occ[level];
    else                   sel = '1;
    found = 1'b0;
    idx   = '0;
    for (int j = NCELLS - 1; j >= 0; j--) begin
      if (!sel[j]) begin
        found = 1'b1;
        idx   = AW'(j);
      end
    end
    addr = AW'(idx << level);
  end
endmodule

// File: rtl/buddy_marker.sv
// Range decoder: one bit per cell, set for cells in [start, start+len).
module buddy_marker #(
  parameter int NCELLS = 256,
  parameter int AW     = $clog2(NCELLS),
  parameter int SW     = AW + 1
) (
  input  logic [AW-1:0]     start,
  input  logic [SW-1:0]     len,
  output logic [NCELLS-1:0] mask
);
  always_comb begin
    for (int i = 0; i < NCELLS; i++) begin
      mask[i] = (i >= int'(start)) && (i < int'(start) + int'(len));
    end
  end
endmodule

// File: rtl/buddy_alloc_top.sv
module buddy_alloc_top #(
  parameter int NCELLS = 256,
  parameter int AW     = $clog2(NCELLS),
  parameter int SW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [SW-1:0] cmd_size,
  input  logic [AW-1:0] cmd_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_fail,
  output logic [AW-1:0] rsp_addr
);
  import buddy_alloc_pkg::*;

  localparam int LW = $clog2(SW + 1);

  logic [NCELLS-1:0] map_q;
  logic [LW-1:0]     lvl;
  logic              loc_found;
  logic [AW-1:0]     loc_addr;
  logic [AW-1:0]     mark_start;
  logic [NCELLS-1:0] mark_mask;
  logic              fire, is_alloc, size_ok, alloc_ok;
  alloc_op_e         op;

  assign op        = alloc_op_e'(cmd_op);
  assign is_alloc  = (op == OP_ALLOC);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  buddy_roundup #(.SW(SW), .LW(LW)) u_round (
    .value (cmd_size),
    .level (lvl)
  );

  buddy_locator #(.NCELLS(NCELLS), .AW(AW), .LW(LW)) u_loc (
    .map   (map_q),
    .level (lvl),
    .found (loc_found),
    .addr  (loc_addr)
  );

  assign mark_start = is_alloc ? loc_addr : cmd_addr;

  buddy_marker #(.NCELLS(NCELLS), .AW(AW), .SW(SW)) u_mark (
    .start (mark_start),
    .len   (cmd_size),
    .mask  (mark_mask)
  );

  assign size_ok  = (cmd_size != '0) && (int'(lvl) <= AW);
  assign alloc_ok = size_ok && loc_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (fire) begin
        rsp_valid <= 1'b1;
        if (is_alloc) begin
          rsp_fail <= !alloc_ok;
          rsp_addr <= alloc_ok ? loc_addr : '0;
          if (alloc_ok) map_q <= map_q | mark_mask;
        end else begin
          rsp_fail <= 1'b0;
          rsp_addr <= cmd_addr;
          map_q    <= map_q & ~mark_mask;
        end
      end
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fail) && $stable(rsp_addr))) else $error("response changed under back-pressure"); // R3
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_alloc && alloc_ok) |-> ((loc_addr & ((AW'(1) << lvl) - AW'(1))) == '0)) else $error("unaligned block"); // R4
  AST_TARGET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_alloc && alloc_ok) |-> ((map_q & mark_mask) == '0)) else $error("allocated over used cells"); // R6
  AST_MARK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_alloc && alloc_ok) |=> ($countones(map_q) == $past($countones(map_q)) + int'($past(cmd_size)))) else $error("wrong count marked"); // R6
  AST_FAIL_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_alloc && !alloc_ok) |=> (map_q == $past(map_q))) else $error("failed alloc changed map"); // R7
  AST_BAD_SIZE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_alloc && ((cmd_size == '0) || (int'(cmd_size) > NCELLS))) |=> (rsp_valid && rsp_fail)) else $error("bad size served"); // R8
endmodule

// File: tb/tb_buddy_alloc_top.sv
`timescale 1ns/1ps
module tb_buddy_alloc_top;
  localparam int N  = 256;
  localparam int AW = 8;
  localparam int SW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [SW-1:0] cmd_size = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_fail;
  logic [AW-1:0] rsp_addr;

  buddy_alloc_top #(.NCELLS(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fail(rsp_fail), .rsp_addr(rsp_addr)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [N-1:0] mdl = '0;
  int live_addr [64];
  int live_size [64];
  int live_n = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void mdl_alloc(input int sz, output bit f, output int a);
    int lvl;
    int blk;
    f = 1'b1;
    a = 0;
    if (sz < 1 || sz > N) return;
    lvl = 0;
    while ((1 << lvl) < sz) lvl++;
    blk = 1 << lvl;
    for (int b = 0; b < N; b += blk) begin
      bit busy = 1'b0;
      for (int k = 0; k < blk; k++) if (mdl[b+k]) busy = 1'b1;
      if (!busy) begin
        f = 1'b0;
        a = b;
        break;
      end
    end
    if (!f) for (int k = 0; k < sz; k++) mdl[a+k] = 1'b1;
  endfunction

  function automatic void mdl_free(input int a, input int sz);
    for (int k = 0; k < sz; k++) if (a + k < N) mdl[a+k] = 1'b0;
  endfunction

  task automatic drive(input bit op, input int sz, input int a);
    cmd_op    = op;
    cmd_size  = SW'(sz);
    cmd_addr  = AW'(a);
    cmd_valid = 1'b1;
  endtask

  // One command, response sampled at the negedge after acceptance.
  task automatic run_cmd(input bit op, input int sz, input int a, input string req);
    bit ef;
    int ea;
    @(negedge clk);
    drive(op, sz, a);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 1'b0) mdl_alloc(sz, ef, ea);
    else begin
      mdl_free(a, sz);
      ef = 1'b0;
      ea = a;
    end
    check(req, int'(rsp_valid), 1, "rsp_valid");
    check(req, int'(rsp_fail), int'(ef), "rsp_fail");
    check(req, int'(rsp_addr), ea, "rsp_addr");
    if (op == 1'b0 && !ef && live_n < 64) begin
      live_addr[live_n] = ea;
      live_size[live_n] = sz;
      live_n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ef;
    int ea;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(rsp_valid), 0, "rsp_valid after reset");
    check("R1", int'(cmd_ready), 1, "cmd_ready after reset");

    // R2 / R3 back-pressure: A accepted, result held, B stalled
    rsp_ready = 1'b0;
    drive(1'b0, 4, 0);
    @(negedge clk);
    mdl_alloc(4, ef, ea);
    check("R2", int'(rsp_valid), 1, "rsp_valid after accept");
    check("R2", int'(cmd_ready), 0, "cmd_ready while blocked");
    check("R4", int'(rsp_addr), ea, "first alloc addr");
    drive(1'b0, 1, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R3", int'(rsp_valid), 1, "held rsp_valid");
      check("R3", int'(rsp_addr), 0, "held rsp_addr");
      check("R3", int'(rsp_fail), 0, "held rsp_fail");
      check("R2", int'(cmd_ready), 0, "cmd_ready stalled");
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    mdl_alloc(1, ef, ea);
    check("R2", int'(rsp_valid), 1, "second result valid");
    check("R6", int'(rsp_addr), 4, "exact mark leaves cell 4 free");
    live_n = 0;

    // Directed corner cases from an empty pool
    run_cmd(1'b1, N, 0, "R9");
    run_cmd(1'b0, 0, 0, "R8");
    run_cmd(1'b0, N + 1, 0, "R8");
    run_cmd(1'b0, N, 0, "R4");
    run_cmd(1'b0, 1, 0, "R7");
    run_cmd(1'b1, 1, 0, "R9");
    run_cmd(1'b0, 2, 0, "R7");
    run_cmd(1'b0, 1, 0, "R7");
    check("R7", int'(rsp_addr), 0, "failed alloc left cell 0 free");
    run_cmd(1'b1, N, 0, "R9");
    run_cmd(1'b1, N, 0, "R9");
    run_cmd(1'b0, 3, 0, "R4");
    run_cmd(1'b0, 1, 0, "R6");
    check("R6", int'(rsp_addr), 3, "tail of rounded block reused");
    run_cmd(1'b0, 2, 0, "R5");
    check("R5", int'(rsp_addr), 4, "lowest aligned pair");
    run_cmd(1'b0, 5, 0, "R5");
    check("R5", int'(rsp_addr), 8, "lowest aligned octet");
    run_cmd(1'b1, 200, 250, "R9");
    run_cmd(1'b0, 129, 0, "R4");
    run_cmd(1'b1, N, 0, "R9");
    live_n = 0;

    // Constrained random mix (R10 op encoding throughout)
    for (int it = 0; it < 800; it++) begin
      int r = int'($urandom % 100);
      if (r < 60 || live_n == 0) begin
        int sz = (($urandom % 8) == 0) ? int'($urandom % (N + 2)) : 1 + int'($urandom % 12);
        run_cmd(1'b0, sz, int'($urandom % N), "R10");
      end else if (r < 95) begin
        int k = int'($urandom % live_n);
        run_cmd(1'b1, live_size[k], live_addr[k], "R10");
        live_addr[k] = live_addr[live_n-1];
        live_size[k] = live_size[live_n-1];
        live_n--;
      end else begin
        run_cmd(1'b1, N, 0, "R9");
        live_n = 0;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule